// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This unit sits beside the fetch stage and answers, in the same cycle, where the next fetch should go. It holds a table of two-bit saturating counters that guess the direction of a branch and a small cache of branch destinations with a valid bit and an address tag per line. Both tables are selected by the low word-address bits of the program counter. A redirect to a cached destination is produced only when the destination cache holds a matching line and the counter leans towards taken. In every other case fetch moves on to the next sequential word.

When a branch resolves later in the pipeline, its address, real outcome, real destination and the guess that was made for it come back through the update port. The unit trains the counter and, for taken branches, writes or refreshes the destination line. In the same cycle it raises a flush request when the guess was wrong. Changes to the tables become visible after the next rising clock edge.

Top module: `branch_predict_unit`

## Requirements
- R1: After reset every counter is in the weakly not-taken state (01) and every destination line is invalid, so any lookup reports pred_hit=0, pred_taken=0 and next_pc=fetch_pc+4.
- R2: The line index is PC[7:2] (64 lines) and the tag is PC[31:8]. pred_hit is 1 only when the indexed line is valid and its tag equals fetch_pc[31:8]. Two addresses with the same index share a counter and a destination line.
- R3: A resolved taken branch moves its counter one step up, saturating at 11. A resolved not-taken branch moves it one step down, saturating at 00. Counter values 10 and 11 make pred_taken=1, and values 00 and 01 make it 0.
- R4: Starting from a saturated counter, one contrary outcome leaves the predicted direction unchanged. A second consecutive contrary outcome flips it.
- R5: next_pc equals pred_target only when pred_hit=1 and pred_taken=1. Otherwise it equals fetch_pc+4, and this includes a counter that leans taken while the destination line misses.
- R6: A resolved taken branch makes its line valid with the branch's tag and destination, overwriting any previous content. A resolved not-taken branch leaves the line unchanged.
- R7: mispredict is 1 in the cycle of an update when upd_taken differs from upd_pred_taken, or when both are 1 and upd_target differs from upd_pred_target. It is 0 when upd_valid=0.
- R8: An update changes what lookups see only after the next rising edge. A lookup of the same line in the update cycle returns the old counter and line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_pc | input | 32 | Address being fetched |
| pred_hit | output | 1 | Destination line valid with matching tag |
| pred_taken | output | 1 | Counter leans taken |
| pred_target | output | 32 | Cached destination of the indexed line |
| next_pc | output | 32 | Address to fetch next |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the branch |
| upd_target | input | 32 | Real destination of the branch |
| upd_pred_taken | input | 1 | Redirect decision that was made at fetch |
| upd_pred_target | input | 32 | Address that was fetched after it when redirected |
| mispredict | output | 1 | Flush request for a wrong guess |

## Verification
Lookup and training can land on the same line in one cycle. That is the case with the most timing risk. The bench provokes it by presenting a fetch address and an update with the same index between two clock edges, with the update chosen so that it would change the hit, the direction and the destination. The lookup must show the old values in that cycle and the new values one edge later. The flush request is also judged in that same update cycle, against the guess the bench supplies.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_STRONG_NT = 2'b00;
    localparam ctr_t CTR_WEAK_NT   = 2'b01;
    localparam ctr_t CTR_WEAK_T    = 2'b10;
    localparam ctr_t CTR_STRONG_T  = 2'b11;

    // one saturating step towards the resolved outcome
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_STRONG_NT) nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bpu_dir_table.sv
module bpu_dir_table
    import bpu_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        ctr_t [DEPTH-1:0] ctr;
    } dir_state_t;

    dir_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (upd_en) begin
            state_d.ctr[upd_idx] = ctr_step(state_q.ctr[upd_idx], upd_taken);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) state_q.ctr[i] <= CTR_WEAK_NT;
        end else begin
            state_q <= state_d;
        end
    end

    // read sees registered contents: same-cycle update is not visible
    assign rd_ctr = state_q.ctr[rd_idx];

    p_sat_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken && state_q.ctr[upd_idx] == CTR_STRONG_T)
        |=> state_q.ctr[$past(upd_idx)] == CTR_STRONG_T);

    p_sat_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_taken && state_q.ctr[upd_idx] == CTR_STRONG_NT)
        |=> state_q.ctr[$past(upd_idx)] == CTR_STRONG_NT);

    p_hold_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_taken && state_q.ctr[upd_idx] == CTR_STRONG_T)
        |=> ctr_says_taken(state_q.ctr[$past(upd_idx)]));

    p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(state_q));

endmodule

// File: rtl/bpu_target_buf.sv
module bpu_target_buf #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [PC_W-IDX_W-3:0] rd_tag,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [PC_W-IDX_W-3:0] upd_tag,
    input  logic [PC_W-1:0]  upd_target
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = PC_W - IDX_W - 2;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  target;
    } line_t;

    typedef struct packed {
        line_t [DEPTH-1:0] line;
    } buf_state_t;

    buf_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (upd_en) begin
            state_d.line[upd_idx].valid  = 1'b1;
            state_d.line[upd_idx].tag    = upd_tag;
            state_d.line[upd_idx].target = upd_target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    line_t rd_line;
    assign rd_line   = state_q.line[rd_idx];
    assign rd_hit    = rd_line.valid && (rd_line.tag == rd_tag);
    assign rd_target = rd_line.target;

    p_alloc_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> state_q.line[$past(upd_idx)].valid
                   && state_q.line[$past(upd_idx)].tag == $past(upd_tag)
                   && state_q.line[$past(upd_idx)].target == $past(upd_target));

    p_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(state_q));

endmodule

// File: rtl/bpu_redirect.sv
module bpu_redirect
    import bpu_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            line_hit,
    input  ctr_t            dir_ctr,
    input  logic [PC_W-1:0] line_target,
    output logic            dir_taken,
    output logic            redirect,
    output logic [PC_W-1:0] next_pc
);
    localparam logic [PC_W-1:0] WORD_STEP = PC_W'(4);

    always_comb begin
        dir_taken = ctr_says_taken(dir_ctr);
        redirect  = line_hit && dir_taken;
        next_pc   = redirect ? line_target : fetch_pc + WORD_STEP;
    end

endmodule

// File: rtl/branch_predict_unit.sv
module branch_predict_unit
    import bpu_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_target,
    output logic [PC_W-1:0] next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_pred_taken,
    input  logic [PC_W-1:0] upd_pred_target,
    output logic            mispredict
);
    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + IDX_W - 1;
    localparam int TAG_W  = PC_W - IDX_W - 2;

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;
    ctr_t             rd_ctr;
    logic             redirect;

    assign rd_idx = fetch_pc[IDX_HI:IDX_LO];
    assign rd_tag = fetch_pc[PC_W-1:IDX_HI+1];
    assign wr_idx = upd_pc[IDX_HI:IDX_LO];
    assign wr_tag = upd_pc[PC_W-1:IDX_HI+1];

    bpu_dir_table #(.IDX_W(IDX_W)) u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (rd_idx),
        .rd_ctr    (rd_ctr),
        .upd_en    (upd_valid),
        .upd_idx   (wr_idx),
        .upd_taken (upd_taken)
    );

    bpu_target_buf #(.PC_W(PC_W), .IDX_W(IDX_W)) u_tgt (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (rd_idx),
        .rd_tag     (rd_tag),
        .rd_hit     (pred_hit),
        .rd_target  (pred_target),
        .upd_en     (upd_valid && upd_taken),
        .upd_idx    (wr_idx),
        .upd_tag    (wr_tag),
        .upd_target (upd_target)
    );

    bpu_redirect #(.PC_W(PC_W)) u_redir (
        .fetch_pc    (fetch_pc),
        .line_hit    (pred_hit),
        .dir_ctr     (rd_ctr),
        .line_target (pred_target),
        .dir_taken   (pred_taken),
        .redirect    (redirect),
        .next_pc     (next_pc)
    );

    // flush when direction or, for a taken branch, the destination was wrong
    always_comb begin
        mispredict = 1'b0;
        if (upd_valid) begin
            if (upd_taken != upd_pred_taken)
                mispredict = 1'b1;
            else if (upd_taken && (upd_target != upd_pred_target))
                mispredict = 1'b1;
        end
    end

    p_flush_needs_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> upd_valid);

    p_jump_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (next_pc != fetch_pc + PC_W'(4)) |-> (pred_hit && pred_taken));

    p_miss_falls_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> (next_pc == fetch_pc + PC_W'(4)));

endmodule

// File: tb/test_branch_predict_unit.sv
module test_branch_predict_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit, pred_taken, mispredict;
    logic [31:0] pred_target, next_pc;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic        upd_pred_taken = 1'b0;
    logic [31:0] upd_pred_target = '0;

    int checks = 0;
    int failures = 0;

    // bench model built from the requirements
    logic [1:0]  m_ctr [64];
    logic        m_val [64];
    logic [23:0] m_tag [64];
    logic [31:0] m_tgt [64];

    always #4 clk = ~clk;

    branch_predict_unit i_branch_predict_unit (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
        .next_pc(next_pc), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_target(upd_target),
        .upd_pred_taken(upd_pred_taken), .upd_pred_target(upd_pred_target),
        .mispredict(mispredict)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) begin
            m_ctr[i] = 2'b01; m_val[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
        end
    endtask

    task automatic model_train(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
        int ix;
        ix = int'(pc[7:2]);
        if (tk && m_ctr[ix] != 2'b11) m_ctr[ix] = m_ctr[ix] + 2'd1;
        if (!tk && m_ctr[ix] != 2'b00) m_ctr[ix] = m_ctr[ix] - 2'd1;
        if (tk) begin m_val[ix] = 1'b1; m_tag[ix] = pc[31:8]; m_tgt[ix] = tgt; end
    endtask

    // compare the combinational lookup at the current fetch_pc against the model
    task automatic check_lookup(input string req, input logic [31:0] pc);
        int ix;
        logic hit, tk;
        ix = int'(pc[7:2]);
        fetch_pc = pc;
        #1;
        hit = m_val[ix] && (m_tag[ix] == pc[31:8]);
        tk  = m_ctr[ix][1];
        check(req, "pred_hit", 32'(pred_hit), 32'(hit));
        check(req, "pred_taken", 32'(pred_taken), 32'(tk));
        check(req, "next_pc", next_pc, (hit && tk) ? m_tgt[ix] : pc + 32'd4);
    endtask

    // one update cycle; flush request judged before the edge
    task automatic do_update(input string req, input logic [31:0] pc, input logic tk,
                             input logic [31:0] tgt, input logic ptk, input logic [31:0] ptgt);
        logic exp_mp;
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
        upd_pred_taken = ptk; upd_pred_target = ptgt;
        #1;
        exp_mp = (tk != ptk) || (tk && ptk && tgt != ptgt);
        check(req, "mispredict", 32'(mispredict), 32'(exp_mp));
        @(posedge clk);
        model_train(pc, tk, tgt);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic t_reset();
        check_lookup("R1", 32'h0000_0000);
        check_lookup("R1", 32'h1234_56FC);
        check("R1", "mispredict idle", 32'(mispredict), 32'd0);
    endtask

    task automatic t_counter_walk();
        logic [31:0] pc = 32'h0000_1010;
        // 01 -> 00 -> 00 (low saturation)
        do_update("R3", pc, 1'b0, 32'h0, 1'b0, 32'h0);
        do_update("R3", pc, 1'b0, 32'h0, 1'b0, 32'h0);
        check_lookup("R3", pc);
        // up to 11 and stay
        for (int i = 0; i < 4; i++) do_update("R3", pc, 1'b1, 32'h0000_2000, 1'b0, 32'h0);
        check_lookup("R3", pc);
        check("R3", "redirect to target", next_pc, 32'h0000_2000);
        // one contrary outcome keeps taken
        do_update("R4", pc, 1'b0, 32'h0, 1'b1, 32'h0000_2000);
        check_lookup("R4", pc);
        check("R4", "still taken after one", 32'(pred_taken), 32'd1);
        // second flips
        do_update("R4", pc, 1'b0, 32'h0, 1'b1, 32'h0000_2000);
        check_lookup("R4", pc);
        check("R4", "flipped after two", 32'(pred_taken), 32'd0);
    endtask

    task automatic t_not_taken_keeps_line();
        logic [31:0] pc = 32'h0000_1010;
        // line still valid with old target after not-taken updates
        check_lookup("R6", pc);
        check("R6", "line kept", 32'(pred_hit), 32'd1);
        check("R6", "target kept", pred_target, 32'h0000_2000);
        do_update("R6", 32'h0000_3020, 1'b0, 32'h0, 1'b0, 32'h0);
        check_lookup("R6", 32'h0000_3020);
        check("R6", "no alloc on not-taken", 32'(pred_hit), 32'd0);
    endtask

    task automatic t_alias();
        logic [31:0] a = 32'h0000_4044;
        logic [31:0] b = 32'h00AB_0044;
        do_update("R2", a, 1'b1, 32'h0000_5000, 1'b0, 32'h0);
        do_update("R2", a, 1'b1, 32'h0000_5000, 1'b0, 32'h0);
        check_lookup("R2", a);
        check("R2", "hit own tag", 32'(pred_hit), 32'd1);
        // same index, other tag: shared counter leans taken but line misses
        check_lookup("R5", b);
        check("R5", "taken but miss falls through", next_pc, b + 32'd4);
        // refresh with the other tag
        do_update("R6", b, 1'b1, 32'h0000_6000, 1'b0, 32'h0);
        check_lookup("R6", b);
        check_lookup("R2", a);
        check("R2", "old tag evicted", 32'(pred_hit), 32'd0);
    endtask

    task automatic t_mispredict();
        do_update("R7", 32'h0000_0100, 1'b1, 32'h0000_0200, 1'b1, 32'h0000_0200);
        do_update("R7", 32'h0000_0100, 1'b1, 32'h0000_0300, 1'b1, 32'h0000_0200);
        do_update("R7", 32'h0000_0100, 1'b0, 32'h0000_0300, 1'b0, 32'h0000_0200);
        do_update("R7", 32'h0000_0100, 1'b0, 32'h0, 1'b1, 32'h0000_0300);
        do_update("R7", 32'h0000_0100, 1'b1, 32'h0000_0300, 1'b0, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] pc = 32'h0000_7088;
        int ix;
        ix = int'(pc[7:2]);
        // bring counter to 01->10 boundary: one taken update in same cycle as lookup
        @(negedge clk);
        fetch_pc = pc;
        upd_valid = 1'b1; upd_pc = pc; upd_taken = 1'b1; upd_target = 32'h0000_8000;
        upd_pred_taken = 1'b0; upd_pred_target = '0;
        #1;
        check("R8", "old hit in update cycle", 32'(pred_hit), 32'(m_val[ix] && m_tag[ix] == pc[31:8]));
        check("R8", "old dir in update cycle", 32'(pred_taken), 32'(m_ctr[ix][1]));
        check("R8", "old next_pc", next_pc, pc + 32'd4);
        check("R7", "flush in update cycle", 32'(mispredict), 32'd1);
        @(posedge clk);
        model_train(pc, 1'b1, 32'h0000_8000);
        @(negedge clk);
        upd_valid = 1'b0;
        check_lookup("R8", pc);
        check("R8", "new target after edge", next_pc, 32'h0000_8000);
    endtask

    initial begin
        model_reset();
        #3;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_counter_walk();
        t_not_taken_keeps_line();
        t_alias();
        t_mispredict();
        t_same_cycle();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule